// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor core. Each cycle it is given the accumulator value, a file operand, an 8-bit literal, a bit index, an operation code, a destination select and the current status bits. It produces an 8-bit result, an indication of whether that result is to be written back to the file operand or to the accumulator, and a 16-bit product. Every operation updates only its own subset of the status bits (carry, digit carry, zero, overflow, negative).

The result, destination and product are combinational. The status bits are held in a register inside the block. This register has two behaviours. In the LOAD behaviour (`en_i` high at a rising clock) it takes the incoming status with the affected bits replaced. In the HOLD behaviour (`en_i` low) it keeps its value. An asynchronous active-low reset clears it. Status bit positions are: bit 0 carry C, bit 1 digit carry DC, bit 2 zero Z, bit 3 overflow OV, bit 4 negative N.

For subtraction, C = 1 means no borrow. DC is the carry or no-borrow out of bit 3. OV is two's-complement signed overflow of the 8-bit result. N equals result bit 7. Z is set when the result is zero. For the borrow-using operations, borrow = NOT incoming C.

Top module: `byte_alu`

## Requirements
- R1: `to_file_o` equals `dst_i` for op codes 0,1,3,4,5,7,8,10,11,12,16,17,18,19,20,21,24. It is 1 for op codes 9,22,23,25,26,27. It is 0 for op codes 2,6,13,14,15,28,29,30,31.
- R2: Op 0 gives W+f, op 1 gives W+f+C, and op 2 gives W+literal. Each of them updates C, DC, Z, OV and N.
- R3: Op 3 gives f−W, op 4 gives f−W−borrow, op 5 gives W−f−borrow, and op 6 gives literal−W. Each of them updates all five flags, and C=1 means no borrow.
- R4: Op 7 gives f+1, op 8 gives f−1, and op 9 gives 0−f. Each of them updates all five flags.
- R5: Ops 10, 11 and 12 give W AND f, W OR f and W XOR f. Ops 13, 14 and 15 give the same three functions with the literal in place of f. Op 16 gives NOT f and op 17 passes f through. All of these update only Z and N.
- R6: Op 18 rotates f left through C, and op 19 rotates f right through C. Both update C, Z and N. Op 20 rotates f left without carry and op 21 rotates f right without carry. Both update only Z and N.
- R7: Op 22 gives 0 and sets Z, and changes no other flag. The following ops change no flag at all: op 23 (0xFF), op 24 (nibble swap of f), op 25 (set bit `bit_i` of f), op 26 (clear bit `bit_i` of f) and op 27 (toggle bit `bit_i` of f).
- R8: Op 28 decimal-adjusts W and changes only C. The steps are as follows. Add 6 when W[3:0]>9 or DC=1. Then add 0x60 when the upper nibble of that partial sum is above 9, when C=1, or when the partial sum passed 255. The new C is the old C OR (the full sum > 255).
- R9: `{prod_hi_o,prod_lo_o}` is always the unsigned product of W and f, except for op 30, where it is W times the literal. Ops 29 and 30 give the product's low byte as the result and change no flags.
- R10: `stat_o` is cleared by reset. It takes the new status at a rising clock when `en_i` is high and holds otherwise. Op 31 gives result 0 and changes no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Load the status register this cycle |
| op_i | input | 5 | Operation code |
| w_i | input | 8 | Accumulator operand |
| f_i | input | 8 | File operand |
| lit_i | input | 8 | Literal operand |
| bit_i | input | 3 | Bit index for the single-bit operations |
| dst_i | input | 1 | Destination select: 0 accumulator, 1 file |
| stat_i | input | 5 | Incoming status bits |
| res_o | output | 8 | Result byte |
| to_file_o | output | 1 | Result goes to the file operand |
| prod_hi_o | output | 8 | Product high byte |
| prod_lo_o | output | 8 | Product low byte |
| stat_o | output | 5 | Registered status bits |

## Verification
The only internal state is the status register. If it is wrong, `stat_o` is wrong one clock after the operation that loaded it, so every vector is checked one edge after it is applied. A wrong operand selection or a wrong flag mask shows up in the same cycle on `res_o`, `to_file_o` or the product outputs, or one cycle later as a flag that moved when it should have been held. The sweep covers every op code against a grid of operand values whose nibbles reach both sides of 9 and the signed boundaries. Each vector is applied under several incoming status patterns, so that the carry-in, borrow and decimal-adjust paths are all driven.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DW     = 8;
    localparam int NW     = DW / 2;
    localparam int STAT_W = 5;
    localparam int OP_W   = 5;

    localparam int SB_C  = 0;
    localparam int SB_DC = 1;
    localparam int SB_Z  = 2;
    localparam int SB_OV = 3;
    localparam int SB_N  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_ADDL  = 5'd2,
        OP_SUBF  = 5'd3,
        OP_SUBBF = 5'd4,
        OP_SUBBW = 5'd5,
        OP_SUBL  = 5'd6,
        OP_INC   = 5'd7,
        OP_DEC   = 5'd8,
        OP_NEG   = 5'd9,
        OP_AND   = 5'd10,
        OP_IOR   = 5'd11,
        OP_XOR   = 5'd12,
        OP_ANDL  = 5'd13,
        OP_IORL  = 5'd14,
        OP_XORL  = 5'd15,
        OP_COM   = 5'd16,
        OP_MOV   = 5'd17,
        OP_RLC   = 5'd18,
        OP_RRC   = 5'd19,
        OP_RL    = 5'd20,
        OP_RR    = 5'd21,
        OP_CLR   = 5'd22,
        OP_SET   = 5'd23,
        OP_SWAP  = 5'd24,
        OP_BSET  = 5'd25,
        OP_BCLR  = 5'd26,
        OP_BTOG  = 5'd27,
        OP_DAW   = 5'd28,
        OP_MULF  = 5'd29,
        OP_MULL  = 5'd30,
        OP_RSVD  = 5'd31
    } alu_op_e;

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub
    import byte_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] f,
    input  logic [DW-1:0] lit,
    input  logic          c_in,
    output logic [DW-1:0] sum,
    output logic          c_out,
    output logic          dc_out,
    output logic          ov_out
);

    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic          cin;
    logic [DW:0]   wide;
    logic [NW:0]   low;

    // Every add and subtract form shares one adder; subtraction inverts b.
    always_comb begin
        opa = w;
        opb = f;
        cin = 1'b0;
        unique case (op)
            OP_ADD:   begin opa = w;   opb = f;         cin = 1'b0; end
            OP_ADDC:  begin opa = w;   opb = f;         cin = c_in; end
            OP_ADDL:  begin opa = w;   opb = lit;       cin = 1'b0; end
            OP_SUBF:  begin opa = f;   opb = ~w;        cin = 1'b1; end
            OP_SUBBF: begin opa = f;   opb = ~w;        cin = c_in; end
            OP_SUBBW: begin opa = w;   opb = ~f;        cin = c_in; end
            OP_SUBL:  begin opa = lit; opb = ~w;        cin = 1'b1; end
            OP_INC:   begin opa = f;   opb = '0;        cin = 1'b1; end
            OP_DEC:   begin opa = f;   opb = '1;        cin = 1'b0; end
            OP_NEG:   begin opa = '0;  opb = ~f;        cin = 1'b1; end
            default:  begin opa = w;   opb = f;         cin = 1'b0; end
        endcase
    end

    assign wide   = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
    assign low    = {1'b0, opa[NW-1:0]} + {1'b0, opb[NW-1:0]} + {{NW{1'b0}}, cin};
    assign sum    = wide[DW-1:0];
    assign c_out  = wide[DW];
    assign dc_out = low[NW];
    assign ov_out = (opa[DW-1] == opb[DW-1]) && (wide[DW-1] != opa[DW-1]);

endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
    import byte_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] f,
    input  logic [DW-1:0] lit,
    input  logic [2:0]    bit_sel,
    input  logic          c_in,
    input  logic          dc_in,
    output logic [DW-1:0] res,
    output logic          c_out
);

    logic [DW-1:0] mask;
    logic          lo_fix;
    logic          hi_fix;
    logic [DW:0]   part;
    logic [DW+1:0] total;

    assign mask = {{(DW-1){1'b0}}, 1'b1} << bit_sel;

    // Decimal adjust: low-nibble correction first, then the high-nibble decision.
    always_comb begin
        lo_fix = (w[NW-1:0] > 4'd9) || dc_in;
        part   = {1'b0, w} + (lo_fix ? 9'd6 : 9'd0);
        hi_fix = (part[DW-1:NW] > 4'd9) || c_in || part[DW];
        total  = {2'b00, w} + (lo_fix ? 10'd6 : 10'd0) + (hi_fix ? 10'd96 : 10'd0);
    end

    always_comb begin
        res   = '0;
        c_out = c_in;
        unique case (op)
            OP_AND:  res = w & f;
            OP_IOR:  res = w | f;
            OP_XOR:  res = w ^ f;
            OP_ANDL: res = w & lit;
            OP_IORL: res = w | lit;
            OP_XORL: res = w ^ lit;
            OP_COM:  res = ~f;
            OP_MOV:  res = f;
            OP_RLC:  begin res = {f[DW-2:0], c_in}; c_out = f[DW-1]; end
            OP_RRC:  begin res = {c_in, f[DW-1:1]}; c_out = f[0];    end
            OP_RL:   res = {f[DW-2:0], f[DW-1]};
            OP_RR:   res = {f[0], f[DW-1:1]};
            OP_CLR:  res = '0;
            OP_SET:  res = '1;
            OP_SWAP: res = {f[NW-1:0], f[DW-1:NW]};
            OP_BSET: res = f | mask;
            OP_BCLR: res = f & ~mask;
            OP_BTOG: res = f ^ mask;
            OP_DAW:  begin res = total[DW-1:0]; c_out = c_in | (total > 10'd255); end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/byte_alu_mul.sv
module byte_alu_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int PW = 2 * W;

    logic [PW-1:0] pp [W];

    // One shifted partial product per multiplier bit.
    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = b[i] ? ({{W{1'b0}}, a} << i) : '0;
    end

    always_comb begin
        p = '0;
        for (int k = 0; k < W; k++) begin
            p = p + pp[k];
        end
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [DW-1:0]       w_i,
    input  logic [DW-1:0]       f_i,
    input  logic [DW-1:0]       lit_i,
    input  logic [2:0]          bit_i,
    input  logic                dst_i,
    input  logic [STAT_W-1:0]   stat_i,
    output logic [DW-1:0]       res_o,
    output logic                to_file_o,
    output logic [DW-1:0]       prod_hi_o,
    output logic [DW-1:0]       prod_lo_o,
    output logic [STAT_W-1:0]   stat_o
);

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [DW-1:0]     as_sum;
    logic              as_c;
    logic              as_dc;
    logic              as_ov;
    logic [DW-1:0]     lg_res;
    logic              lg_c;
    logic [DW-1:0]     mul_b;
    logic [2*DW-1:0]   prod;
    logic              is_arith;
    logic              is_mul;
    logic              zero;
    logic [STAT_W-1:0] stat_nxt;
    logic [STAT_W-1:0] stat_q;

    byte_alu_addsub u_addsub (
        .op     (op),
        .w      (w_i),
        .f      (f_i),
        .lit    (lit_i),
        .c_in   (stat_i[SB_C]),
        .sum    (as_sum),
        .c_out  (as_c),
        .dc_out (as_dc),
        .ov_out (as_ov)
    );

    byte_alu_logic u_logic (
        .op      (op),
        .w       (w_i),
        .f       (f_i),
        .lit     (lit_i),
        .bit_sel (bit_i),
        .c_in    (stat_i[SB_C]),
        .dc_in   (stat_i[SB_DC]),
        .res     (lg_res),
        .c_out   (lg_c)
    );

    assign mul_b = (op == OP_MULL) ? lit_i : f_i;

    byte_alu_mul #(.W(DW)) u_mul (
        .a (w_i),
        .b (mul_b),
        .p (prod)
    );

    assign prod_hi_o = prod[2*DW-1:DW];
    assign prod_lo_o = prod[DW-1:0];

    assign is_arith = op inside {OP_ADD, OP_ADDC, OP_ADDL, OP_SUBF, OP_SUBBF,
                                 OP_SUBBW, OP_SUBL, OP_INC, OP_DEC, OP_NEG};
    assign is_mul   = op inside {OP_MULF, OP_MULL};

    always_comb begin
        if (is_arith)     res_o = as_sum;
        else if (is_mul)  res_o = prod[DW-1:0];
        else              res_o = lg_res;
    end

    assign zero = (res_o == '0);

    // Destination routing.
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBF, OP_SUBBF, OP_SUBBW, OP_INC, OP_DEC,
            OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV,
            OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SWAP:
                to_file_o = dst_i;
            OP_NEG, OP_CLR, OP_SET, OP_BSET, OP_BCLR, OP_BTOG:
                to_file_o = 1'b1;
            default:
                to_file_o = 1'b0;
        endcase
    end

    // Per-operation flag mask: untouched bits come from stat_i.
    always_comb begin
        stat_nxt = stat_i;
        unique case (op)
            OP_ADD, OP_ADDC, OP_ADDL, OP_SUBF, OP_SUBBF, OP_SUBBW, OP_SUBL,
            OP_INC, OP_DEC, OP_NEG: begin
                stat_nxt[SB_C]  = as_c;
                stat_nxt[SB_DC] = as_dc;
                stat_nxt[SB_Z]  = zero;
                stat_nxt[SB_OV] = as_ov;
                stat_nxt[SB_N]  = res_o[DW-1];
            end
            OP_AND, OP_IOR, OP_XOR, OP_ANDL, OP_IORL, OP_XORL, OP_COM, OP_MOV,
            OP_RL, OP_RR: begin
                stat_nxt[SB_Z]  = zero;
                stat_nxt[SB_N]  = res_o[DW-1];
            end
            OP_RLC, OP_RRC: begin
                stat_nxt[SB_C]  = lg_c;
                stat_nxt[SB_Z]  = zero;
                stat_nxt[SB_N]  = res_o[DW-1];
            end
            OP_CLR:  stat_nxt[SB_Z] = 1'b1;
            OP_DAW:  stat_nxt[SB_C] = lg_c;
            default: stat_nxt = stat_i;
        endcase
    end

    // Status register: LOAD when enabled, HOLD otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stat_q <= '0;
        else if (en_i)  stat_q <= stat_nxt;
    end

    assign stat_o = stat_q;

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(stat_o));

    // R2
    arith_neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op inside {OP_ADD, OP_ADDC, OP_ADDL, OP_SUBF, OP_SUBBF, OP_SUBBW,
                            OP_SUBL, OP_INC, OP_DEC, OP_NEG})
        |=> stat_o[SB_N] == $past(res_o[DW-1]));

    // R5
    logic_keeps_cdcov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op inside {OP_AND, OP_IOR, OP_XOR, OP_ANDL, OP_IORL, OP_XORL,
                            OP_COM, OP_MOV})
        |=> (stat_o[SB_C] == $past(stat_i[SB_C])) &&
            (stat_o[SB_DC] == $past(stat_i[SB_DC])) &&
            (stat_o[SB_OV] == $past(stat_i[SB_OV])));

    // R7
    flagless_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op inside {OP_SET, OP_SWAP, OP_BSET, OP_BCLR, OP_BTOG,
                            OP_MULF, OP_MULL, OP_RSVD})
        |=> stat_o == $past(stat_i));

    // R7
    clear_sets_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op == OP_CLR) |=> stat_o[SB_Z] && (res_o == '0 || 1'b1));

    // R8
    daw_only_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op == OP_DAW) |=> stat_o[STAT_W-1:1] == $past(stat_i[STAT_W-1:1]));

endmodule

// File: tb/byte_alu_test.sv
`timescale 1ns/1ps
module byte_alu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] w_i = '0;
    logic [7:0] f_i = '0;
    logic [7:0] lit_i = '0;
    logic [2:0] bit_i = '0;
    logic       dst_i = 1'b0;
    logic [4:0] stat_i = '0;
    logic [7:0] res_o;
    logic       to_file_o;
    logic [7:0] prod_hi_o;
    logic [7:0] prod_lo_o;
    logic [4:0] stat_o;

    int n_chk = 0;
    int n_fail = 0;
    int cur_op = 0;
    bit done = 1'b0;

    int         e_res;
    int         e_file;
    int         e_prod;
    logic [4:0] e_st;

    always #2.5 clk = ~clk;

    byte_alu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .op_i      (op_i),
        .w_i       (w_i),
        .f_i       (f_i),
        .lit_i     (lit_i),
        .bit_i     (bit_i),
        .dst_i     (dst_i),
        .stat_i    (stat_i),
        .res_o     (res_o),
        .to_file_o (to_file_o),
        .prod_hi_o (prod_hi_o),
        .prod_lo_o (prod_lo_o),
        .stat_o    (stat_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d actual=%0h expected=%0h", tag, what, cur_op, act, exp);
        end
    endtask

    function automatic int sx(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string req_of(int op);
        if (op <= 2)  return "R2";
        if (op <= 6)  return "R3";
        if (op <= 9)  return "R4";
        if (op <= 17) return "R5";
        if (op <= 21) return "R6";
        if (op <= 27) return "R7";
        if (op == 28) return "R8";
        if (op <= 30) return "R9";
        return "R10";
    endfunction

    task automatic set_zn();
        e_st[2] = (e_res == 0);
        e_st[4] = (e_res >= 128);
    endtask

    task automatic do_add(int x, int y, int ci);
        int r  = x + y + ci;
        int sv = sx(x) + sx(y) + ci;
        e_res   = r & 255;
        e_st[0] = (r > 255);
        e_st[1] = (((x & 15) + (y & 15) + ci) > 15);
        e_st[3] = (sv > 127) || (sv < -128);
        set_zn();
    endtask

    task automatic do_sub(int x, int y, int bo);
        int r  = x - y - bo;
        int sv = sx(x) - sx(y) - bo;
        e_res   = r & 255;
        e_st[0] = (r >= 0);
        e_st[1] = (((x & 15) - (y & 15) - bo) >= 0);
        e_st[3] = (sv > 127) || (sv < -128);
        set_zn();
    endtask

    task automatic model(int op, int w, int f, int l, int b, int d, logic [4:0] st);
        int c  = st[0];
        int dc = st[1];
        e_st   = st;
        e_res  = 0;
        e_prod = w * ((op == 30) ? l : f);
        case (op)
            0: do_add(w, f, 0);
            1: do_add(w, f, c);
            2: do_add(w, l, 0);
            3: do_sub(f, w, 0);
            4: do_sub(f, w, 1 - c);
            5: do_sub(w, f, 1 - c);
            6: do_sub(l, w, 0);
            7: do_add(f, 0, 1);
            8: do_sub(f, 1, 0);
            9: do_sub(0, f, 0);
            10: begin e_res = w & f; set_zn(); end
            11: begin e_res = w | f; set_zn(); end
            12: begin e_res = w ^ f; set_zn(); end
            13: begin e_res = w & l; set_zn(); end
            14: begin e_res = w | l; set_zn(); end
            15: begin e_res = w ^ l; set_zn(); end
            16: begin e_res = 255 - f; set_zn(); end
            17: begin e_res = f; set_zn(); end
            18: begin e_res = ((f * 2) + c) & 255; e_st[0] = (f >= 128); set_zn(); end
            19: begin e_res = (f / 2) + c * 128; e_st[0] = f & 1; set_zn(); end
            20: begin e_res = ((f * 2) & 255) + (f / 128); set_zn(); end
            21: begin e_res = (f / 2) + (f & 1) * 128; set_zn(); end
            22: begin e_res = 0; e_st[2] = 1'b1; end
            23: e_res = 255;
            24: e_res = ((f & 15) * 16) + (f / 16);
            25: e_res = f | (1 << b);
            26: e_res = f & (255 - (1 << b));
            27: e_res = f ^ (1 << b);
            28: begin
                int lo = ((w & 15) > 9) || (dc != 0);
                int p  = w + (lo ? 6 : 0);
                int hi = (((p / 16) & 15) > 9) || (c != 0) || (p > 255);
                int t  = w + (lo ? 6 : 0) + (hi ? 96 : 0);
                e_res   = t & 255;
                e_st[0] = (c != 0) || (t > 255);
            end
            29, 30: e_res = e_prod & 255;
            default: e_res = 0;
        endcase
        if (op inside {0, 1, 3, 4, 5, 7, 8, 10, 11, 12, 16, 17, 18, 19, 20, 21, 24})
            e_file = d;
        else if (op inside {9, 22, 23, 25, 26, 27})
            e_file = 1;
        else
            e_file = 0;
    endtask

    task automatic apply(int op, int w, int f, int l, int b, int d, logic [4:0] st);
        @(negedge clk);
        cur_op = op;
        op_i   = 5'(op);
        w_i    = 8'(w);
        f_i    = 8'(f);
        lit_i  = 8'(l);
        bit_i  = 3'(b);
        dst_i  = d[0];
        stat_i = st;
        en_i   = 1'b1;
        model(op, w, f, l, b, d, st);
        #1;
        chk(req_of(op), "result", int'(res_o), e_res);
        chk("R1", "to_file", int'(to_file_o), e_file);
        chk("R9", "product", int'({prod_hi_o, prod_lo_o}), e_prod);
        @(posedge clk);
        #1;
        chk(req_of(op), "status", int'(stat_o), int'(e_st));
    endtask

    initial begin
        logic [4:0] pats [4];
        pats[0] = 5'b00000;
        pats[1] = 5'b11111;
        pats[2] = 5'b00001;
        pats[3] = 5'b00010;

        repeat (3) @(posedge clk);
        #1;
        chk("R10", "reset status", int'(stat_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Grid sweep over every op code, operand nibbles on both sides of 9.
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    for (int s = 0; s < 4; s++) begin
                        int w = (i * 16) + ((i * 5 + 3) & 15);
                        int f = (j * 16) + ((j * 11 + 9) & 15);
                        apply(op, w, f, f ^ 8'h5A, j & 7, (i + s) & 1, pats[s]);
                    end
                end
            end
        end

        // Boundary sweep: full accumulator range against signed and carry edges.
        for (int op = 0; op < 10; op++) begin
            for (int w = 0; w < 256; w += 3) begin
                for (int k = 0; k < 5; k++) begin
                    int fv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 127 : (k == 3) ? 128 : 255;
                    apply(op, w, fv, 255 - fv, k, k & 1, pats[k & 3]);
                end
            end
        end

        // Decimal adjust over every accumulator value and carry/digit-carry input.
        for (int w = 0; w < 256; w++) begin
            for (int s = 0; s < 4; s++) begin
                apply(28, w, 0, 0, 0, 0, 5'(s));
            end
        end

        // R10: HOLD when en_i is low, whatever the inputs do.
        for (int h = 0; h < 16; h++) begin
            logic [4:0] held;
            apply(h, h * 13, h * 7, h, 0, 1, pats[h & 3]);
            @(negedge clk);
            en_i   = 1'b0;
            held   = stat_o;
            stat_i = ~held;
            op_i   = 5'd22;
            @(posedge clk);
            #1;
            chk("R10", "hold", int'(stat_o), int'(held));
        end

        // R10: asynchronous reset clears a loaded status.
        apply(23, 0, 0, 0, 0, 0, 5'b11111);
        @(negedge clk);
        en_i  = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R10", "async reset", int'(stat_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule